// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Core Timing Selector

This block lives inside a memory controller and enforces four core DRAM timing limits for every bank: the wait from row open to column access, the minimum time a row stays open before it may be closed, the recovery time after a write before a close, and the wait from a close to the next open. The limits are not fixed constants. The block holds four profiled sets of them, one for each of four temperature points (55, 65, 75 and 85 °C), and chooses the set that is safe for the latest temperature reading. Sets are swapped while the controller runs. The DRAM is neither reset nor reprogrammed.

Each reading is rounded up to the next profiled point. A reading above the hottest point, or one marked invalid, forces the hottest set. That set is the standard worst-case set: 11 cycles row-to-column, 28 cycles open-to-close and 11 cycles close-to-open for a 1600 MT/s part. A hotter set is taken on the first reading that calls for it. A cooler set is taken only after a programmable number of consecutive cooler readings. A new set takes effect only on a cycle with no command, so no command is ever timed against a mix of two sets. Timers that are already running keep the values loaded under the old set.

The scheduler watches three per-bank permission flags and issues commands only when they allow. A small write port loads the sets and the cool-down count.

Top module: `dram_temp_timing_sel`

## Requirements
- R1: After reset the active set index is 3 (85 °C) and every permission flag of every bank is 1. All four sets start with the worst-case values: row-to-column 11, open-to-close 28, write recovery 12, close-to-open 11.
- R2: A write with `prog_addr[4]`=0 stores `prog_data` into set `prog_addr[3:2]`, field `prog_addr[1:0]`. The field codes are 0 row-to-column, 1 open-to-close, 2 write recovery and 3 close-to-open. A write with `prog_addr[4]`=1 stores the cool-down count.
- R3: A reading maps to a set index as follows: ≤55 gives 0, 56–65 gives 1, 66–75 gives 2, and anything above 75 gives 3. A reading with `temp_bad`=1 gives 3 whatever its value.
- R4: A reading whose set index is hotter than the requested one becomes the requested set at once.
- R5: A cooler set is requested only after N consecutive readings cooler than the requested set, where N is the cool-down count (0 acts as 1). The new set is the hottest index seen in that run. A reading equal to the requested set restarts the run.
- R6: The requested set becomes active (and visible on `set_idx`) only on a clock edge where `cmd_valid`=0. A set requested at edge E is active after edge E+1 if that cycle is idle.
- R7: An activate (`cmd_type`=0) to a bank drops its `rw_ok`. The flag returns exactly row-to-column cycles later.
- R8: `pre_ok` of a bank is 1 only when open-to-close cycles have passed since its last activate and write-recovery cycles have passed since its last write (`cmd_type`=2). A read (`cmd_type`=1) loads no timer.
- R9: A precharge (`cmd_type`=3) drops `act_ok` of that bank for exactly close-to-open cycles.
- R10: A set switch does not change a running timer. A reload takes the larger of the remaining time and the new value, so a timer never ends earlier than its first load dictated.
- R11: Commands to one bank leave the flags of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | A temperature reading is present this cycle |
| temp_val | input | TW | Reading in whole degrees Celsius, unsigned |
| temp_bad | input | 1 | Reading is untrustworthy |
| prog_we | input | 1 | Table write strobe |
| prog_addr | input | 5 | Table address (bit 4 selects the cool-down count) |
| prog_data | input | CW | Value to write |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BW | Target bank |
| act_ok | output | NB | Per bank: activate permitted |
| rw_ok | output | NB | Per bank: read or write permitted |
| pre_ok | output | NB | Per bank: precharge permitted |
| set_idx | output | 2 | Active set, 0 = 55 °C up to 3 = 85 °C |

## Verification
The bench targets the exact threshold readings 55 and 75, a cooling run with a hotter reading inside it, a run restarted by an equal reading, and an invalid reading carrying a cold value. A design with an off-by-one in rounding, or one that takes the last reading instead of the hottest in the run, would choose too fast a set. Hot readings arrive while commands are issued every cycle. A design that switches in the middle of that stream would show a new `set_idx` too early. Timers are started under the hot set and checked after a cool switch and after a reload. A design that reloads blindly or rescales running timers would raise a flag early.

// File: rtl/dram_temp_timing_sel.sv
module dram_temp_timing_sel #(
  parameter int NB = 4,
  parameter int CW = 6,
  parameter int TW = 8,
  parameter int HW = 4,
  parameter int T0 = 55,
  parameter int T1 = 65,
  parameter int T2 = 75,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          temp_valid,
  input  logic [TW-1:0] temp_val,
  input  logic          temp_bad,
  input  logic          prog_we,
  input  logic [4:0]    prog_addr,
  input  logic [CW-1:0] prog_data,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_type,
  input  logic [BW-1:0] cmd_bank,
  output logic [NB-1:0] act_ok,
  output logic [NB-1:0] rw_ok,
  output logic [NB-1:0] pre_ok,
  output logic [1:0]    set_idx
);
  localparam logic [1:0] C_ACT = 2'd0, C_WR = 2'd2, C_PRE = 2'd3;
  localparam int F_RCD = 0, F_RAS = 1, F_WR = 2, F_RP = 3;
  localparam logic [CW-1:0] D_RCD = CW'(11), D_RAS = CW'(28), D_WR = CW'(12), D_RP = CW'(11);

  logic [3:0][3:0][CW-1:0] tbl;
  logic [HW-1:0] cool_need, streak;
  logic [1:0] req_set, act_set, run_max, tgt, nmax;
  logic [HW:0] need_eff;
  logic [CW-1:0] cur_rcd, cur_ras, cur_wr, cur_rp;
  logic [NB-1:0][CW-1:0] rcd_c, ras_c, wr_c, rp_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin
        tbl[s][F_RCD] <= D_RCD;
        tbl[s][F_RAS] <= D_RAS;
        tbl[s][F_WR]  <= D_WR;
        tbl[s][F_RP]  <= D_RP;
      end
      cool_need <= HW'(4);
    end else if (prog_we) begin
      if (prog_addr[4]) cool_need <= prog_data[HW-1:0];
      else tbl[prog_addr[3:2]][prog_addr[1:0]] <= prog_data;
    end
  end

  always_comb begin
    if (temp_bad || temp_val > TW'(T2)) tgt = 2'd3;
    else if (temp_val > TW'(T1))        tgt = 2'd2;
    else if (temp_val > TW'(T0))        tgt = 2'd1;
    else                                tgt = 2'd0;
  end

  assign need_eff = (cool_need == '0) ? (HW+1)'(1) : {1'b0, cool_need};
  assign nmax = (streak == '0 || tgt > run_max) ? tgt : run_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_set <= 2'd3;
      act_set <= 2'd3;
      streak  <= '0;
      run_max <= 2'd0;
    end else begin
      if (temp_valid) begin
        if (tgt >= req_set) begin
          if (tgt > req_set) req_set <= tgt;
          streak <= '0;
        end else if ({1'b0, streak} + 1'b1 >= need_eff) begin
          req_set <= nmax;
          streak  <= '0;
        end else begin
          streak  <= streak + 1'b1;
          run_max <= nmax;
        end
      end
      if (!cmd_valid) act_set <= req_set;
    end
  end

  assign set_idx = act_set;
  assign cur_rcd = tbl[act_set][F_RCD];
  assign cur_ras = tbl[act_set][F_RAS];
  assign cur_wr  = tbl[act_set][F_WR];
  assign cur_rp  = tbl[act_set][F_RP];

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] c, input logic ld, input logic [CW-1:0] v);
    logic [CW-1:0] d;
    d = (c == '0) ? '0 : c - 1'b1;
    return (ld && v > d) ? v : d;
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = cmd_valid && (cmd_bank == BW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rcd_c[b] <= '0;
        ras_c[b] <= '0;
        wr_c[b]  <= '0;
        rp_c[b]  <= '0;
      end else begin
        rcd_c[b] <= tick(rcd_c[b], hit && cmd_type == C_ACT, cur_rcd);
        ras_c[b] <= tick(ras_c[b], hit && cmd_type == C_ACT, cur_ras);
        wr_c[b]  <= tick(wr_c[b],  hit && cmd_type == C_WR,  cur_wr);
        rp_c[b]  <= tick(rp_c[b],  hit && cmd_type == C_PRE, cur_rp);
      end
    end
    assign rw_ok[b]  = rcd_c[b] == '0;
    assign pre_ok[b] = ras_c[b] == '0 && wr_c[b] == '0;
    assign act_ok[b] = rp_c[b] == '0;
  end
endmodule

// File: rtl/dram_temp_timing_chk.sv
module dram_temp_timing_chk #(
  parameter int NB = 4,
  parameter int CW = 6,
  parameter int BW = 2
) (
  input logic clk,
  input logic rst_n,
  input logic temp_valid,
  input logic temp_bad,
  input logic cmd_valid,
  input logic [1:0] cmd_type,
  input logic [BW-1:0] cmd_bank,
  input logic [1:0] req_set,
  input logic [1:0] set_idx,
  input logic [CW-1:0] cur_rcd,
  input logic [NB-1:0] rw_ok,
  input logic [NB-1:0][CW-1:0] rp_c
);
  a_r3_bad_forces_hot: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid && temp_bad |=> req_set == 2'd3);

  a_r5_cool_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    req_set < $past(req_set) |-> $past(temp_valid));

  a_r6_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    set_idx != $past(set_idx) |-> !$past(cmd_valid));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    a_r7_rcd_block: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_type == 2'd0 && cmd_bank == BW'(b) && cur_rcd != '0 |=> !rw_ok[b]);
    a_r10_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rp_c[b]) != '0 |-> rp_c[b] >= $past(rp_c[b]) - 1'b1);
  end
endmodule

bind dram_temp_timing_sel dram_temp_timing_chk #(.NB(NB), .CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_bad(temp_bad),
  .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
  .req_set(req_set), .set_idx(set_idx), .cur_rcd(cur_rcd), .rw_ok(rw_ok), .rp_c(rp_c)
);

// File: tb/test_dram_temp_timing_sel.sv
module test_dram_temp_timing_sel;
  logic clk = 0, rst_n = 0;
  logic temp_valid = 0, temp_bad = 0, prog_we = 0, cmd_valid = 0;
  logic [7:0] temp_val = 0;
  logic [4:0] prog_addr = 0;
  logic [5:0] prog_data = 0;
  logic [1:0] cmd_type = 0;
  logic [1:0] cmd_bank = 0;
  logic [3:0] act_ok, rw_ok, pre_ok;
  logic [1:0] set_idx;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dram_temp_timing_sel i_dram_temp_timing_sel (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic prog(input int s, input int f, input int v);
    prog_we = 1; prog_addr = 5'((s << 2) | f); prog_data = 6'(v);
    step();
    prog_we = 0;
  endtask

  task automatic sample(input int t, input bit bad, input int exp, input string req);
    temp_valid = 1; temp_val = 8'(t); temp_bad = bad;
    step();
    temp_valid = 0; temp_bad = 0;
    step();
    step();
    chk(set_idx == 2'(exp), req, set_idx, exp);
  endtask

  function automatic bit flag(input int kind, input int b);
    case (kind)
      0: return act_ok[b];
      1: return rw_ok[b];
      default: return pre_ok[b];
    endcase
  endfunction

  // kind: 0 act_ok, 1 rw_ok, 2 pre_ok; cmd codes 0 ACT 2 WR 3 PRE
  task automatic seq(input string req, input int kind, input int b, input int t0,
                     input int k2, input int t2, input bit cool3, input int exp);
    int first = -1;
    cmd_valid = 1; cmd_type = 2'(t0); cmd_bank = 2'(b);
    step();
    cmd_valid = 0;
    for (int k = 1; k <= 60; k++) begin
      if (k == k2) begin cmd_valid = 1; cmd_type = 2'(t2); cmd_bank = 2'(b); end
      if (cool3 && k <= 3) begin temp_valid = 1; temp_val = 8'd40; end
      step();
      cmd_valid = 0; temp_valid = 0;
      if (first < 0 && flag(kind, b)) first = k;
    end
    chk(first == exp, req, first, exp);
  endtask

  task automatic t_reset();
    chk(set_idx == 2'd3, "R1 set", set_idx, 3);
    chk(act_ok == 4'hF && rw_ok == 4'hF && pre_ok == 4'hF, "R1 flags",
        {act_ok, rw_ok, pre_ok}, 12'hFFF);
  endtask

  task automatic t_worst();
    seq("R1 R7 rcd11", 1, 0, 0, 0, 0, 0, 11);
    seq("R1 R8 ras28", 2, 0, 0, 0, 0, 0, 28);
    seq("R1 R9 rp11", 0, 0, 3, 0, 0, 0, 11);
    seq("R8 wr12 after ACT", 2, 3, 0, 25, 2, 0, 37);
  endtask

  task automatic t_program();
    prog(0, 0, 8); prog(0, 1, 19); prog(0, 2, 6); prog(0, 3, 8);
    prog(1, 0, 9); prog(1, 1, 22); prog(1, 2, 8); prog(1, 3, 9);
    prog(2, 0, 10); prog(2, 1, 25); prog(2, 2, 10); prog(2, 3, 10);
    prog_we = 1; prog_addr = 5'h10; prog_data = 6'd3;
    step();
    prog_we = 0;
  endtask

  task automatic t_cool();
    sample(40, 0, 3, "R5 one sample");
    sample(40, 0, 3, "R5 two samples");
    sample(40, 0, 0, "R5 three samples");
  endtask

  task automatic t_heat();
    sample(60, 0, 1, "R4 R3 60->1");
    sample(75, 0, 2, "R4 R3 75->2");
    sample(76, 0, 3, "R4 R3 76->3");
    sample(70, 0, 3, "R5 run1");
    sample(50, 0, 3, "R5 run2");
    sample(50, 0, 2, "R5 hottest of run");
    sample(40, 0, 2, "R5 restart a");
    sample(75, 0, 2, "R5 equal resets");
    sample(40, 0, 2, "R5 restart b");
    sample(40, 0, 2, "R5 restart c");
    sample(55, 0, 0, "R3 R5 55->0");
    sample(20, 1, 3, "R3 bad");
  endtask

  task automatic t_boundary();
    sample(40, 0, 3, "R5 c1");
    sample(40, 0, 3, "R5 c2");
    sample(40, 0, 0, "R5 c3");
    cmd_valid = 1; cmd_type = 2'd1; cmd_bank = 2'd3;
    temp_valid = 1; temp_val = 8'd90;
    step();
    temp_valid = 0;
    for (int i = 0; i < 5; i++) step();
    chk(set_idx == 2'd0, "R6 held during commands", set_idx, 0);
    cmd_valid = 0;
    step();
    chk(set_idx == 2'd3, "R6 applied when idle", set_idx, 3);
  endtask

  task automatic t_no_shrink();
    seq("R10 rp keeps old 11", 0, 1, 3, 0, 0, 1, 11);
    chk(set_idx == 2'd0, "R10 switched", set_idx, 0);
    sample(90, 0, 3, "R4 back hot");
    seq("R10 ras reload max", 2, 0, 0, 5, 0, 1, 28);
    sample(90, 0, 3, "R4 back hot 2");
    seq("R10 rcd reload new", 1, 0, 0, 5, 0, 1, 13);
  endtask

  task automatic t_cool_timing();
    seq("R7 R2 rcd8", 1, 2, 0, 0, 0, 0, 8);
    seq("R8 ras19 dominates", 2, 2, 0, 10, 2, 0, 19);
    seq("R8 wr6 dominates", 2, 1, 0, 16, 2, 0, 22);
    seq("R8 read loads nothing", 2, 1, 0, 16, 1, 0, 19);
    seq("R9 rp8", 0, 1, 3, 0, 0, 0, 8);
  endtask

  task automatic t_banks();
    cmd_valid = 1; cmd_type = 2'd0; cmd_bank = 2'd2;
    step();
    cmd_valid = 0;
    chk(rw_ok == 4'b1011, "R11 only bank2 blocked", rw_ok, 4'b1011);
    chk(pre_ok == 4'b1011 && act_ok == 4'hF, "R11 other flags", {act_ok, pre_ok}, 8'hFB);
    for (int i = 0; i < 40; i++) step();
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1;
    step();
    t_reset();
    t_worst();
    t_program();
    t_cool();
    t_cool_timing();
    t_heat();
    t_boundary();
    t_no_shrink();
    t_banks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule